// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block sits right after instruction fetch. It takes a window of six bytes read at the current program counter and breaks it into the fields that later stages need: the operation and variant nibbles, two register identifiers, a 32-bit constant, the byte length of the instruction and the address of the following instruction. It also reports whether the instruction is legal, and whether it is the stop instruction. The block is purely combinational. Its outputs follow its inputs within the same cycle.

The first byte alone fixes the length, which is 1, 2, 5 or 6 bytes. Depending on the operation, a register byte and a four-byte little-endian constant may follow. Any register field the encoding lacks is reported as the "no register" code 0xF. A constant is reported as zero when the encoding has none. An illegal encoding is reported as a one-byte instruction with no fields, so the next-address output still moves forward.

Top module: `insn_field_decoder`

## Requirements
- R1: `iCode` equals bits [7:4] of byte 0 and `iFun` equals bits [3:0] of byte 0. Byte k of the window sits at `fetchBytes[8k+7:8k]`.
- R2: For a legal instruction, `insnLen` is 1 for operation codes 0x0 (nop), 0x1 (halt) and 0x9 (return). It is 2 for 0x2 (register move), 0x6 (arithmetic), 0xA (push) and 0xB (pop). It is 5 for 0x7 (branch) and 0x8 (call). It is 6 for 0x3 (immediate move), 0x4 (store) and 0x5 (load).
- R3: For operation codes 0x2 to 0x6, 0xA and 0xB, `regA` is bits [7:4] of byte 1 and `regB` is bits [3:0] of byte 1. Both nibbles pass through unchanged, including 0xF.
- R4: For operation codes 0x0, 0x1, 0x7, 0x8 and 0x9, and for every illegal encoding, `regA` and `regB` are both 0xF.
- R5: For operation codes 0x3, 0x4 and 0x5, `constVal` is bytes 2 to 5 taken little-endian, so byte 2 is the least significant byte.
- R6: For operation codes 0x7 and 0x8, `constVal` is bytes 1 to 4 taken little-endian, and byte 5 has no effect on it.
- R7: For every other operation code and for every illegal encoding, `constVal` is 0.
- R8: `pcNext` equals `pcIn + insnLen` modulo 2^32.
- R9: An encoding is illegal if the operation code is above 0xB, or code 0x6 has a variant above 3, or code 0x7 has a variant above 6, or any other code has a nonzero variant. An illegal encoding drives `status` to 4 and `insnLen` to 1.
- R10: `status` is 2 for a legal halt (byte 0 = 0x10) and 1 for every other legal encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcIn | input | 32 | Address of byte 0 of the window |
| fetchBytes | input | 48 | Six fetched bytes, byte 0 in the low bits |
| iCode | output | 4 | Operation code nibble |
| iFun | output | 4 | Variant nibble |
| regA | output | 4 | First register identifier, 0xF when absent |
| regB | output | 4 | Second register identifier, 0xF when absent |
| constVal | output | 32 | Immediate, displacement or destination |
| insnLen | output | 3 | Instruction length in bytes |
| pcNext | output | 32 | Address of the following instruction |
| status | output | 3 | 1 = normal, 2 = halt, 4 = illegal encoding |

## Verification
Each of the twelve operation codes is applied in at least one legal form, with junk in the trailing bytes, which shows whether the decoder reads bytes it should ignore. Constants with distinct values in every byte tell the offset-1 layout from the offset-2 layout and detect a reversed byte order. Variants at the legal limits and one step past them, an operation code above 0xB, and a halt with a nonzero variant separate the legality rules from one another. A program counter close to 2^32 checks that the next address wraps.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int NIB_W       = 4;
  localparam int CONST_BYTES = WORD_W / BYTE_W;
  localparam int FETCH_BYTES = 2 + CONST_BYTES;
  localparam int FETCH_W     = FETCH_BYTES * BYTE_W;
  localparam int LEN_W       = $clog2(FETCH_BYTES + 1);
  localparam int STAT_W      = 3;

  typedef enum logic [NIB_W-1:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_RMOV  = 4'h2,
    OP_IMOV  = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_BR    = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  localparam logic [NIB_W-1:0]  REG_NONE   = 4'hF;
  localparam logic [NIB_W-1:0]  ALU_FUN_MAX = 4'h3;
  localparam logic [NIB_W-1:0]  BR_FUN_MAX  = 4'h6;
  localparam logic [STAT_W-1:0] ST_AOK = 3'd1;
  localparam logic [STAT_W-1:0] ST_HLT = 3'd2;
  localparam logic [STAT_W-1:0] ST_INS = 3'd4;

  typedef struct packed {
    logic             hasReg;
    logic             hasConst;
    logic             constAtOne;
    logic             badInsn;
    logic             isHalt;
    logic [LEN_W-1:0] lenBytes;
  } ctrl_strobes_t;
endpackage

// File: rtl/ild_ctrl.sv
module ild_ctrl
  import ild_pkg::*;
(
  input  logic [NIB_W-1:0] iCode,
  input  logic [NIB_W-1:0] iFun,
  output ctrl_strobes_t    strobes
);
  logic funOk;
  logic codeOk;

  always_comb begin
    codeOk = 1'b1;
    funOk  = (iFun == '0);
    case (iCode)
      OP_ALU:  funOk = (iFun <= ALU_FUN_MAX);
      OP_BR:   funOk = (iFun <= BR_FUN_MAX);
      OP_NOP, OP_HALT, OP_RMOV, OP_IMOV, OP_STORE, OP_LOAD,
      OP_CALL, OP_RET, OP_PUSH, OP_POP: funOk = (iFun == '0);
      default: codeOk = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.lenBytes = LEN_W'(1);
    if (!(codeOk && funOk)) begin
      strobes.badInsn = 1'b1;
    end else begin
      case (iCode)
        OP_HALT: strobes.isHalt = 1'b1;
        OP_RMOV, OP_ALU, OP_PUSH, OP_POP: begin
          strobes.hasReg   = 1'b1;
          strobes.lenBytes = LEN_W'(2);
        end
        OP_IMOV, OP_STORE, OP_LOAD: begin
          strobes.hasReg   = 1'b1;
          strobes.hasConst = 1'b1;
          strobes.lenBytes = LEN_W'(2 + CONST_BYTES);
        end
        OP_BR, OP_CALL: begin
          strobes.hasConst   = 1'b1;
          strobes.constAtOne = 1'b1;
          strobes.lenBytes   = LEN_W'(1 + CONST_BYTES);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_BAD_IS_SHORT: assert (!strobes.badInsn ||
      (strobes.lenBytes == LEN_W'(1) && !strobes.hasReg && !strobes.hasConst))
      else $error("illegal encoding not reduced to one byte"); // R9
    AST_HALT_LEGAL: assert (!strobes.isHalt || (iCode == OP_HALT && iFun == '0))
      else $error("halt flagged on non-halt encoding"); // R10
  end
endmodule

// File: rtl/ild_pc_adder.sv
module ild_pc_adder
  import ild_pkg::*;
(
  input  logic [WORD_W-1:0] pcIn,
  input  logic [LEN_W-1:0]  lenBytes,
  output logic [WORD_W-1:0] pcNext
);
  always_comb pcNext = pcIn + {{(WORD_W-LEN_W){1'b0}}, lenBytes};

  always_comb begin
    AST_PC_ADVANCES: assert (pcNext != pcIn)
      else $error("next address did not move"); // R8
  end
endmodule

// File: rtl/ild_datapath.sv
module ild_datapath
  import ild_pkg::*;
(
  input  logic [FETCH_W-1:0] fetchBytes,
  input  logic [WORD_W-1:0]  pcIn,
  input  ctrl_strobes_t      strobes,
  output logic [NIB_W-1:0]   regA,
  output logic [NIB_W-1:0]   regB,
  output logic [WORD_W-1:0]  constVal,
  output logic [LEN_W-1:0]   insnLen,
  output logic [WORD_W-1:0]  pcNext,
  output logic [STAT_W-1:0]  status
);
  logic [BYTE_W-1:0] byteArr [FETCH_BYTES];
  logic [WORD_W-1:0] constEarly;
  logic [WORD_W-1:0] constLate;

  for (genvar b = 0; b < FETCH_BYTES; b++) begin : g_split
    assign byteArr[b] = fetchBytes[b*BYTE_W +: BYTE_W];
  end

  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
    assign constEarly[k*BYTE_W +: BYTE_W] = byteArr[1 + k];
    assign constLate[k*BYTE_W +: BYTE_W]  = byteArr[2 + k];
  end

  always_comb begin
    regA = REG_NONE;
    regB = REG_NONE;
    if (strobes.hasReg) begin
      regA = byteArr[1][BYTE_W-1 -: NIB_W];
      regB = byteArr[1][NIB_W-1:0];
    end
  end

  always_comb begin
    constVal = '0;
    if (strobes.hasConst) constVal = strobes.constAtOne ? constEarly : constLate;
  end

  always_comb begin
    if (strobes.badInsn)     status = ST_INS;
    else if (strobes.isHalt) status = ST_HLT;
    else                     status = ST_AOK;
  end

  assign insnLen = strobes.lenBytes;

  ild_pc_adder u_pcAdd (
    .pcIn     (pcIn),
    .lenBytes (insnLen),
    .pcNext   (pcNext)
  );

  always_comb begin
    AST_LEN_LEGAL: assert (insnLen == LEN_W'(1) || insnLen == LEN_W'(2) ||
      insnLen == LEN_W'(1 + CONST_BYTES) || insnLen == LEN_W'(2 + CONST_BYTES))
      else $error("length out of set"); // R2
    AST_ABSENT_REG_NONE: assert (strobes.hasReg || (regA == REG_NONE && regB == REG_NONE))
      else $error("absent register field not 0xF"); // R4
    AST_NO_CONST_ZERO: assert (strobes.hasConst || constVal == '0)
      else $error("constant nonzero without constant field"); // R7
    AST_STATUS_ONEHOT: assert ($onehot(status))
      else $error("status not one-hot"); // R10
  end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import ild_pkg::*;
(
  input  logic [31:0] pcIn,
  input  logic [47:0] fetchBytes,
  output logic [3:0]  iCode,
  output logic [3:0]  iFun,
  output logic [3:0]  regA,
  output logic [3:0]  regB,
  output logic [31:0] constVal,
  output logic [2:0]  insnLen,
  output logic [31:0] pcNext,
  output logic [2:0]  status
);
  ctrl_strobes_t strobes;

  assign iCode = fetchBytes[BYTE_W-1 -: NIB_W];
  assign iFun  = fetchBytes[NIB_W-1:0];

  ild_ctrl u_ctrl (
    .iCode   (iCode),
    .iFun    (iFun),
    .strobes (strobes)
  );

  ild_datapath u_dp (
    .fetchBytes (fetchBytes),
    .pcIn       (pcIn),
    .strobes    (strobes),
    .regA       (regA),
    .regB       (regB),
    .constVal   (constVal),
    .insnLen    (insnLen),
    .pcNext     (pcNext),
    .status     (status)
  );

  always_comb begin
    AST_ILLEGAL_ONE_BYTE: assert (status != ST_INS || pcNext == pcIn + 32'd1)
      else $error("illegal encoding did not advance by one"); // R9
  end
endmodule

// File: tb/tb_insn_field_decoder.sv
module tb_insn_field_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pcIn;
  logic [47:0] fetchBytes;
  logic [3:0]  iCode, iFun, regA, regB;
  logic [31:0] constVal, pcNext;
  logic [2:0]  insnLen, status;

  insn_field_decoder dut (
    .pcIn(pcIn), .fetchBytes(fetchBytes), .iCode(iCode), .iFun(iFun),
    .regA(regA), .regB(regB), .constVal(constVal), .insnLen(insnLen),
    .pcNext(pcNext), .status(status)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic done = 1'b0;

  localparam int NV = 19;
  // byte 0 in the low bits
  localparam logic [47:0] VB [NV] = '{
    48'h000000000010, 48'h000000000000, 48'h000000004320, 48'h0000abcdf230,
    48'h0000041c6440, 48'hfffffff41550, 48'h000000002561, 48'haa1234567873,
    48'hee1122334480, 48'hffeeddccbb90, 48'h000000003fa0, 48'h000000007fb0,
    48'h1122334455c0, 48'h000000001264, 48'h000000001277, 48'h000000000001,
    48'h000000000176, 48'h000000000163, 48'h000000000011};
  localparam logic [2:0]  VL [NV] = '{1,1,2,6,6,6,2,5,5,1,2,2,1,1,1,1,5,2,1};
  localparam logic [7:0]  VR [NV] = '{8'hff,8'hff,8'h43,8'hf2,8'h64,8'h15,8'h25,8'hff,
    8'hff,8'hff,8'h3f,8'h7f,8'hff,8'hff,8'hff,8'hff,8'hff,8'h01,8'hff};
  localparam logic [31:0] VC [NV] = '{32'h0,32'h0,32'h0,32'h0000abcd,32'h0000041c,
    32'hfffffff4,32'h0,32'h12345678,32'h11223344,32'h0,32'h0,32'h0,32'h0,32'h0,
    32'h0,32'h0,32'h00000001,32'h0,32'h0};
  localparam logic [2:0]  VS [NV] = '{2,1,1,1,1,1,1,1,1,1,1,1,4,4,4,4,1,1,4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [47:0] b);
    @(negedge clk);
    pcIn = pc;
    fetchBytes = b;
    #1;
  endtask

  initial begin
    pcIn = '0;
    fetchBytes = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state: all-zero window is a nop at address 0
    check("R2 reset len", {29'd0, insnLen}, 32'd1);
    check("R8 reset pcNext", pcNext, 32'd1);
    check("R10 reset status", {29'd0, status}, 32'd1);
    check("R4 reset regs", {24'd0, regA, regB}, 32'hff);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      pc = 32'h0000_0100 + 32'(i) * 32'h0001_0010;
      apply(pc, VB[i]);
      check("R1 iCode", {28'd0, iCode}, {28'd0, VB[i][7:4]});
      check("R1 iFun", {28'd0, iFun}, {28'd0, VB[i][3:0]});
      check("R2/R9 len", {29'd0, insnLen}, {29'd0, VL[i]});
      check("R3/R4 regs", {24'd0, regA, regB}, {24'd0, VR[i]});
      check("R5/R6/R7 const", constVal, VC[i]);
      check("R9/R10 status", {29'd0, status}, {29'd0, VS[i]});
      check("R8 pcNext", pcNext, pc + {29'd0, VL[i]});
    end

    // R8 wrap
    apply(32'hffff_fffe, 48'h0000abcdf230);
    check("R8 wrap", pcNext, 32'h0000_0004);
    // R6 byte 5 ignored by branch
    apply(32'h0, 48'h001234567870);
    check("R6 byte5 ignored", constVal, 32'h12345678);
    apply(32'h0, 48'hff1234567870);
    check("R6 byte5 ignored", constVal, 32'h12345678);
    // R5 byte 1 not part of constant for load
    apply(32'h0, 48'h44332211ee50);
    check("R5 byte order", constVal, 32'h44332211);
    // R3 pass-through of 0xF on both nibbles
    apply(32'h0, 48'h000000ffff20);
    check("R3 F passthrough", {24'd0, regA, regB}, 32'hff);
    // R9 highest code
    apply(32'h10, 48'h1234567890f0);
    check("R9 code F", {29'd0, status}, 32'd4);
    check("R7 const bad", constVal, 32'd0);
    check("R8 bad advance", pcNext, 32'h11);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end else if (cycles > 10000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule